// File: doc/BRIEF.md
# Page Table Entry Access Checker

This block judges one memory access against a page table entry that some other unit has already fetched. Each request gives the 64-bit entry, the kind of access (load, store or instruction fetch), whether the processor is in user mode, and the 13-bit offset within the 8 KiB page. One clock later the block returns either a 46-bit physical address or a fault with a cause code. On a successful access it also returns the entry with its status bits updated, and a strobe that says whether that entry must go back to memory.

The entry layout is fixed by the block. Bit 0 is the present flag. Bits 1, 2 and 3 grant load, store and fetch. Bit 4 marks a page that user mode may touch. Bit 5 is the accessed flag and bit 6 the dirty flag. Bits 14:7 hold an 8-bit protection key, and bits 47:15 hold the 33-bit frame number. Bits 63:48 belong to software and are carried through unchanged. Two 256-bit masks, one bit per key, deny loads and fetches (read mask) or stores (write mask) for the selected key.

Top module: `pte_check_unit`

## Requirements
- R1: A request accepted at a clock edge gives `resp_valid` high for exactly the following cycle. A cycle with no request gives `resp_valid`, `resp_fault`, `resp_cause`, `resp_paddr`, `resp_wb` and `resp_wb_pte` all zero in the next cycle.
- R2: On success, `resp_paddr` equals entry bits 47:15 followed by `req_offset`, and `resp_cause` is 0.
- R3: If entry bit 0 is clear, the response faults with cause 1 (not present), and `resp_paddr` is zero.
- R4: A user-mode request (`req_user`=1) to an entry whose bit 4 is clear faults with cause 2 (privilege). A supervisor request is never refused for that reason.
- R5: Access kind 0 (load) needs bit 1, kind 1 (store) needs bit 2, and kind 2 (fetch) needs bit 3. Kind 3 is reserved and always fails. A missing grant faults with cause 3 (permission).
- R6: For the key k in entry bits 14:7, a load or fetch faults with cause 4 (key) when `key_rd_deny[k]` is 1, and a store does so when `key_wr_deny[k]` is 1.
- R7: When several faults apply, only the first in this order is reported: not-present, privilege, permission, key.
- R8: On success, the updated entry has bit 5 set and, for a store, bit 6 set. Every other bit matches the request entry.
- R9: `resp_wb` is 1 only when the updated entry differs from the request entry and the access did not fault. Otherwise `resp_wb` and `resp_wb_pte` are zero.
- R10: While reset is held, and in the first cycle after it, all response outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_pte | input | 64 | Fetched page table entry |
| req_kind | input | 2 | 0 load, 1 store, 2 fetch, 3 reserved |
| req_user | input | 1 | 1 when the access comes from user mode |
| req_offset | input | 13 | Byte offset inside the page |
| key_rd_deny | input | 256 | Per-key denial of loads and fetches |
| key_wr_deny | input | 256 | Per-key denial of stores |
| resp_valid | output | 1 | Response strobe, one cycle after the request |
| resp_fault | output | 1 | Access refused |
| resp_cause | output | 3 | 0 none, 1 not present, 2 privilege, 3 permission, 4 key |
| resp_paddr | output | 46 | Physical address, zero on a fault |
| resp_wb | output | 1 | Updated entry must be written back |
| resp_wb_pte | output | 64 | Updated entry, zero when no write-back |

## Verification
Every result (`resp_valid`, cause, address, write-back strobe and updated entry) comes from a single register stage. Each result is therefore due on the first rising edge after the request is applied. The bench drives inputs on a falling edge and reads all outputs on the next falling edge, half a period after that register updates. It then drops the strobe, so each response belongs to exactly one request. Idle cycles are read in the same way, one falling edge after the strobe goes low.

// File: rtl/pte_chk_pkg.sv
// Shared encodings for the page table entry access checker.
// Assumes a fixed flag layout in the low entry bits; the key and frame
// positions follow from the key width chosen in the top module.
package pte_chk_pkg;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_kind_e;

    typedef enum logic [2:0] {
        CAUSE_NONE   = 3'd0,
        CAUSE_ABSENT = 3'd1,
        CAUSE_PRIV   = 3'd2,
        CAUSE_PERM   = 3'd3,
        CAUSE_KEY    = 3'd4
    } cause_e;

    localparam int unsigned BIT_VALID = 0;
    localparam int unsigned BIT_RD    = 1;
    localparam int unsigned BIT_WR    = 2;
    localparam int unsigned BIT_EX    = 3;
    localparam int unsigned BIT_USER  = 4;
    localparam int unsigned BIT_ACC   = 5;
    localparam int unsigned BIT_DIRTY = 6;
    localparam int unsigned KEY_LSB   = 7;

endpackage

// File: rtl/pte_fault_eval.sv
// Fault evaluation: turns the entry flags, the key and the request kind into
// one cause code. Purely combinational. Assumes the caller has already sliced
// the flag fields out of the entry. The priority order is fixed.
module pte_fault_eval
    import pte_chk_pkg::*;
#(
    parameter int unsigned KEY_W = 8,
    localparam int unsigned NKEYS = 1 << KEY_W
) (
    input  logic             present,
    input  logic [2:0]       grant,      // {fetch, store, load}
    input  logic             user_page,
    input  logic [KEY_W-1:0] key,
    input  logic [1:0]       kind,
    input  logic             user_mode,
    input  logic [NKEYS-1:0] key_rd_deny,
    input  logic [NKEYS-1:0] key_wr_deny,
    output logic [2:0]       cause
);

    logic priv_bad;
    logic perm_bad;
    logic key_bad;

    // Decide which individual checks fail for this request kind.
    always_comb begin
        priv_bad = user_mode && !user_page;
        case (kind)
            ACC_LOAD:  perm_bad = !grant[0];
            ACC_STORE: perm_bad = !grant[1];
            ACC_FETCH: perm_bad = !grant[2];
            default:   perm_bad = 1'b1;
        endcase
        if (kind == ACC_STORE) key_bad = key_wr_deny[key];
        else                   key_bad = key_rd_deny[key];
    end

    // Report only the highest-priority failing check.
    always_comb begin
        if (!present)      cause = CAUSE_ABSENT;
        else if (priv_bad) cause = CAUSE_PRIV;
        else if (perm_bad) cause = CAUSE_PERM;
        else if (key_bad)  cause = CAUSE_KEY;
        else               cause = CAUSE_NONE;
    end

endmodule

// File: rtl/pte_status_update.sv
// Status update: forms the entry as it must look after a successful access
// (accessed set, dirty also set for stores) and flags whether it changed.
// Assumes the result is discarded by the caller when the access faults.
module pte_status_update
    import pte_chk_pkg::*;
#(
    parameter int unsigned PTE_W = 64
) (
    input  logic [PTE_W-1:0] pte_in,
    input  logic [1:0]       kind,
    output logic [PTE_W-1:0] pte_out,
    output logic             changed
);

    // Set the status flags and compare with the original entry.
    always_comb begin
        pte_out          = pte_in;
        pte_out[BIT_ACC] = 1'b1;
        if (kind == ACC_STORE) pte_out[BIT_DIRTY] = 1'b1;
        changed = (pte_out != pte_in);
    end

endmodule

// File: rtl/pte_addr_form.sv
// Address formation: joins the frame number with the untranslated page
// offset. Assumes the frame width plus offset width equals the output width.
module pte_addr_form #(
    parameter int unsigned PFN_W  = 33,
    parameter int unsigned OFF_W  = 13,
    localparam int unsigned PA_W  = PFN_W + OFF_W
) (
    input  logic [PFN_W-1:0] frame,
    input  logic [OFF_W-1:0] offset,
    output logic [PA_W-1:0]  paddr
);

    // Concatenate frame and offset.
    always_comb paddr = {frame, offset};

endmodule

// File: rtl/pte_check_unit.sv
// Top of the entry access checker. Slices the entry, evaluates faults,
// forms the address and the updated entry, and registers one response per
// request. Assumes the entry was already fetched for this access and that
// a response is consumed in the cycle it is shown.
module pte_check_unit
    import pte_chk_pkg::*;
#(
    parameter int unsigned PTE_W   = 64,
    parameter int unsigned PA_W    = 46,
    parameter int unsigned PG_BITS = 13,
    parameter int unsigned KEY_W   = 8,
    localparam int unsigned PFN_W     = PA_W - PG_BITS,
    localparam int unsigned FRAME_LSB = KEY_LSB + KEY_W,
    localparam int unsigned NKEYS     = 1 << KEY_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [PTE_W-1:0]   req_pte,
    input  logic [1:0]         req_kind,
    input  logic               req_user,
    input  logic [PG_BITS-1:0] req_offset,
    input  logic [NKEYS-1:0]   key_rd_deny,
    input  logic [NKEYS-1:0]   key_wr_deny,
    output logic               resp_valid,
    output logic               resp_fault,
    output logic [2:0]         resp_cause,
    output logic [PA_W-1:0]    resp_paddr,
    output logic               resp_wb,
    output logic [PTE_W-1:0]   resp_wb_pte
);

    logic [2:0]       cause_c;
    logic [PA_W-1:0]  paddr_c;
    logic [PTE_W-1:0] upd_pte_c;
    logic             upd_changed_c;
    logic             ok_c;

    pte_fault_eval #(
        .KEY_W (KEY_W)
    ) u_fault (
        .present     (req_pte[BIT_VALID]),
        .grant       ({req_pte[BIT_EX], req_pte[BIT_WR], req_pte[BIT_RD]}),
        .user_page   (req_pte[BIT_USER]),
        .key         (req_pte[KEY_LSB +: KEY_W]),
        .kind        (req_kind),
        .user_mode   (req_user),
        .key_rd_deny (key_rd_deny),
        .key_wr_deny (key_wr_deny),
        .cause       (cause_c)
    );

    pte_addr_form #(
        .PFN_W (PFN_W),
        .OFF_W (PG_BITS)
    ) u_addr (
        .frame  (req_pte[FRAME_LSB +: PFN_W]),
        .offset (req_offset),
        .paddr  (paddr_c)
    );

    pte_status_update #(
        .PTE_W (PTE_W)
    ) u_status (
        .pte_in  (req_pte),
        .kind    (req_kind),
        .pte_out (upd_pte_c),
        .changed (upd_changed_c)
    );

    // Success when no check failed.
    always_comb ok_c = (cause_c == CAUSE_NONE);

    // Register one response per request; idle cycles give all zeros.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid  <= 1'b0;
            resp_fault  <= 1'b0;
            resp_cause  <= CAUSE_NONE;
            resp_paddr  <= '0;
            resp_wb     <= 1'b0;
            resp_wb_pte <= '0;
        end else if (req_valid) begin
            resp_valid  <= 1'b1;
            resp_fault  <= !ok_c;
            resp_cause  <= cause_c;
            resp_paddr  <= ok_c ? paddr_c : '0;
            resp_wb     <= ok_c && upd_changed_c;
            resp_wb_pte <= (ok_c && upd_changed_c) ? upd_pte_c : '0;
        end else begin
            resp_valid  <= 1'b0;
            resp_fault  <= 1'b0;
            resp_cause  <= CAUSE_NONE;
            resp_paddr  <= '0;
            resp_wb     <= 1'b0;
            resp_wb_pte <= '0;
        end
    end

endmodule

// File: rtl/pte_chk_props.sv
// Checker for pte_check_unit: timing and fault properties seen at the ports.
// Attached to every instance of the top by the bind below.
module pte_chk_props #(
    parameter int unsigned PTE_W = 64,
    parameter int unsigned PA_W  = 46
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic [PTE_W-1:0] req_pte,
    input logic [1:0]       req_kind,
    input logic             req_user,
    input logic             resp_valid,
    input logic             resp_fault,
    input logic [2:0]       resp_cause,
    input logic [PA_W-1:0]  resp_paddr,
    input logic             resp_wb,
    input logic [PTE_W-1:0] resp_wb_pte
);

    p_resp_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> resp_valid);

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!resp_valid && !resp_fault && !resp_wb));

    p_absent_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_pte[0]) |=> (resp_fault && resp_cause == 3'd1 && resp_paddr == '0));

    p_priv_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_pte[0] && req_user && !req_pte[4]) |=> (resp_cause == 3'd2));

    p_rsvd_kind_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == 2'd3) |=> resp_fault);

    p_wb_accessed_r8: assert property (@(posedge clk) disable iff (!rst_n)
        resp_wb |-> resp_wb_pte[5]);

    p_no_wb_fault_r9: assert property (@(posedge clk) disable iff (!rst_n)
        resp_fault |-> (!resp_wb && resp_wb_pte == '0));

endmodule

bind pte_check_unit pte_chk_props #(
    .PTE_W (PTE_W),
    .PA_W  (PA_W)
) u_props (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_pte     (req_pte),
    .req_kind    (req_kind),
    .req_user    (req_user),
    .resp_valid  (resp_valid),
    .resp_fault  (resp_fault),
    .resp_cause  (resp_cause),
    .resp_paddr  (resp_paddr),
    .resp_wb     (resp_wb),
    .resp_wb_pte (resp_wb_pte)
);

// File: tb/sim_pte_check_unit.sv
// Bench for pte_check_unit: directed corner cases then seeded random vectors,
// all compared with a reference model written from the requirements.
module sim_pte_check_unit;

    localparam int CLK_PERIOD = 10;
    localparam int N_RANDOM   = 3000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic [63:0]  req_pte = '0;
    logic [1:0]   req_kind = '0;
    logic         req_user = 1'b0;
    logic [12:0]  req_offset = '0;
    logic [255:0] key_rd_deny = '0;
    logic [255:0] key_wr_deny = '0;
    logic         resp_valid;
    logic         resp_fault;
    logic [2:0]   resp_cause;
    logic [45:0]  resp_paddr;
    logic         resp_wb;
    logic [63:0]  resp_wb_pte;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    pte_check_unit u0 (
        .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_pte (req_pte),
        .req_kind (req_kind), .req_user (req_user), .req_offset (req_offset),
        .key_rd_deny (key_rd_deny), .key_wr_deny (key_wr_deny),
        .resp_valid (resp_valid), .resp_fault (resp_fault), .resp_cause (resp_cause),
        .resp_paddr (resp_paddr), .resp_wb (resp_wb), .resp_wb_pte (resp_wb_pte)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL R1 watchdog expired: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    function automatic logic [63:0] mk_pte(input bit v, input bit r, input bit w,
            input bit x, input bit u, input bit a, input bit d,
            input logic [7:0] key, input logic [32:0] pfn);
        logic [63:0] p = '0;
        p[0] = v; p[1] = r; p[2] = w; p[3] = x; p[4] = u; p[5] = a; p[6] = d;
        p[14:7] = key; p[47:15] = pfn; p[63:48] = 16'hA5C3;
        return p;
    endfunction

    // Reference model built from the requirement text.
    function automatic void model(input logic [63:0] p, input logic [1:0] k,
            input bit usr, input logic [12:0] off,
            output logic [2:0] cause, output logic [45:0] pa,
            output bit wb, output logic [63:0] wbp);
        logic [7:0]  key = p[14:7];
        logic [63:0] np;
        bit perm_ok;
        perm_ok = (k == 2'd0 && p[1]) || (k == 2'd1 && p[2]) || (k == 2'd2 && p[3]);
        if (!p[0])                      cause = 3'd1;
        else if (usr && !p[4])          cause = 3'd2;
        else if (!perm_ok)              cause = 3'd3;
        else if ((k == 2'd1 && key_wr_deny[key]) || (k != 2'd1 && key_rd_deny[key]))
                                        cause = 3'd4;
        else                            cause = 3'd0;
        pa = '0; wb = 1'b0; wbp = '0;
        if (cause == 3'd0) begin
            pa = {p[47:15], off};
            np = p; np[5] = 1'b1;
            if (k == 2'd1) np[6] = 1'b1;
            wb = (np != p);
            if (wb) wbp = np;
        end
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic string cause_tag(input logic [2:0] c);
        case (c)
            3'd1: return "R3 cause";
            3'd2: return "R4 cause";
            3'd4: return "R6 cause";
            default: return "R5 cause";
        endcase
    endfunction

    // Apply one request, then read the response one falling edge later.
    task automatic run_vec(input logic [63:0] p, input logic [1:0] k, input bit usr,
            input logic [12:0] off, input string prio_tag, input int prio_cause);
        logic [2:0] ec; logic [45:0] epa; bit ewb; logic [63:0] ewp;
        @(negedge clk);
        req_valid = 1'b1; req_pte = p; req_kind = k; req_user = usr; req_offset = off;
        model(p, k, usr, off, ec, epa, ewb, ewp);
        @(negedge clk);
        chk("R1 resp_valid", 64'(resp_valid), 64'd1);
        chk(cause_tag(ec), 64'(resp_cause), 64'(ec));
        chk("R7 fault flag", 64'(resp_fault), 64'(ec != 3'd0));
        chk("R2 paddr", 64'(resp_paddr), 64'(epa));
        chk("R9 wb strobe", 64'(resp_wb), 64'(ewb));
        chk("R8 wb entry", resp_wb_pte, ewp);
        if (prio_cause >= 0) chk(prio_tag, 64'(resp_cause), 64'(prio_cause));
        req_valid = 1'b0;
    endtask

    task automatic check_quiet(input string tag);
        chk({tag, " valid"}, 64'(resp_valid), 64'd0);
        chk({tag, " fault"}, 64'(resp_fault), 64'd0);
        chk({tag, " cause"}, 64'(resp_cause), 64'd0);
        chk({tag, " paddr"}, 64'(resp_paddr), 64'd0);
        chk({tag, " wb"}, 64'(resp_wb), 64'd0);
        chk({tag, " wb entry"}, resp_wb_pte, 64'd0);
    endtask

    initial begin
        void'($urandom(32'd7351));
        repeat (3) @(negedge clk);
        check_quiet("R10 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_quiet("R10 after reset");

        key_rd_deny[5] = 1'b1;
        key_wr_deny[5] = 1'b1;
        // R7: every fault present; not-present wins.
        run_vec(mk_pte(0, 0, 0, 0, 0, 0, 0, 8'd5, 33'h1), 2'd0, 1, 13'h1, "R7 absent first", 1);
        // R7: privilege beats permission and key.
        run_vec(mk_pte(1, 0, 0, 0, 0, 0, 0, 8'd5, 33'h2), 2'd1, 1, 13'h2, "R7 privilege second", 2);
        // R7: permission beats key.
        run_vec(mk_pte(1, 1, 0, 1, 1, 0, 0, 8'd5, 33'h3), 2'd1, 1, 13'h3, "R7 permission third", 3);
        // R6: key denial for store alone.
        run_vec(mk_pte(1, 1, 1, 1, 1, 0, 0, 8'd5, 33'h4), 2'd1, 0, 13'h4, "R6 key store", 4);
        // R4: supervisor may use a supervisor-only page.
        run_vec(mk_pte(1, 1, 1, 1, 0, 0, 0, 8'd9, 33'h1ABCDEF01), 2'd2, 0, 13'h1FFF, "R4 supervisor ok", 0);
        // R9: store to an entry already accessed and dirty needs no write-back.
        run_vec(mk_pte(1, 1, 1, 0, 1, 1, 1, 8'd9, 33'h1FFFFFFFF), 2'd1, 1, 13'h0, "R9 no change", 0);
        // R8: load on a fresh entry sets accessed only.
        run_vec(mk_pte(1, 1, 0, 0, 1, 0, 0, 8'd9, 33'h0F0F0F0F0), 2'd0, 1, 13'h0AA, "R8 load sets accessed", 0);
        // R8: store on a fresh entry sets accessed and dirty.
        run_vec(mk_pte(1, 1, 1, 1, 1, 0, 0, 8'd9, 33'h123456789), 2'd1, 1, 13'h155, "R8 store sets dirty", 0);
        // R5: reserved kind always fails even with every grant.
        run_vec(mk_pte(1, 1, 1, 1, 1, 1, 1, 8'd9, 33'h5), 2'd3, 0, 13'h5, "R5 reserved kind", 3);

        // R1: an idle cycle after a request returns all zeros.
        @(negedge clk);
        req_valid = 1'b0; req_pte = '1; req_kind = 2'd1; req_user = 1'b1;
        @(negedge clk);
        check_quiet("R1 idle");

        // Random phase with sparse key masks.
        for (int i = 0; i < 8; i++) begin
            key_rd_deny[i*32 +: 32] = $urandom & $urandom & $urandom;
            key_wr_deny[i*32 +: 32] = $urandom & $urandom & $urandom;
        end
        for (int n = 0; n < N_RANDOM; n++) begin
            logic [63:0] p;
            logic [1:0] k;
            int sel;
            p = {$urandom, $urandom};
            if ($urandom % 8 != 0) p[0] = 1'b1;
            if ($urandom % 4 != 0) p[4] = 1'b1;
            sel = $urandom % 16;
            k = (sel < 5) ? 2'd0 : (sel < 10) ? 2'd1 : (sel < 15) ? 2'd2 : 2'd3;
            run_vec(p, k, 1'($urandom), 13'($urandom), "", -1);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule